// File: doc/BRIEF.md
# Timer Mode and Event Flag Register

This block is the mode register of a small timer unit with three counters. Software programs it over a simple register bus. It picks the count enable for two counters: either a prescaler tick or a rising edge seen on an external pin. It picks the trigger that makes the third counter capture. It also chooses whether the capture event or the end of a slow-tracking one-shot may raise the interrupt.

Two sticky flags record those events. Software clears a flag in two steps: it reads the register with the flag at 1, then writes the flag as 0. If an event arrives in the same cycle as the clearing write, the event wins. While a flag is already set, further events of its kind produce no new interrupt pulse.

Top module: `tmr_mode_ctl`

## Requirements
- R1: After reset, both registers read as 0 and `irq_o` is low.
- R2: Mode bits [1:0] pick the first counter enable: 00 uses a rising edge of `ext_cnt_i`, 01 uses `taps_i[0]` (clock/4), 10 uses `taps_i[1]` (clock/256), 11 uses `taps_i[2]` (clock/512).
- R3: Mode bits [3:2] pick the second counter enable: 00 uses a rising edge of `div_out_i`, 01 uses `taps_i[5]` (clock/4096), 10 uses `taps_i[4]` (clock/2048), 11 uses `taps_i[3]` (clock/1024).
- R4: With mode bit 7 at 0, `capture_o` follows `uflow_i` and aux bit 0 is ignored. With mode bit 7 at 1, aux bit 0 selects the trigger: 0 selects a rising edge of `ext_cnt_i`, 1 selects a rising edge of `irq_pin_i`. In that state `uflow_i` has no effect.
- R5: The capture flag (mode bit 5) sets on a capture event only while mode bit 4 is 0.
- R6: The one-shot flag (mode bit 6) sets on a pulse of `oneshot_end_i` only while mode bit 4 is 1.
- R7: A flag clears only when 0 is written to it after a read that returned it as 1. Writing 1 to a flag bit, or writing 0 without such a read, leaves the flag unchanged.
- R8: When a set event and a clearing write fall in the same cycle, the flag stays 1.
- R9: `irq_o` is a one-cycle pulse in the cycle in which either flag changes from 0 to 1. An event that finds its flag already at 1 gives no pulse.
- R10: A write to the mode register that does not clear a flag cancels that flag's pending read-armed state.
- R11: Mode bits [4:0] and [7] read back as written, and aux bit 0 reads back as written. The other aux bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Bus select |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 1 | 0 selects the mode register, 1 selects the aux register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data; 0 when no read is in progress |
| taps_i | input | 6 | Prescaler tick pulses: clock/4, /256, /512, /1024, /2048, /4096 |
| ext_cnt_i | input | 1 | External count and trigger pin (asynchronous) |
| div_out_i | input | 1 | Frequency divider output (asynchronous) |
| irq_pin_i | input | 1 | External interrupt pin (asynchronous) |
| uflow_i | input | 1 | Second counter underflow pulse |
| oneshot_end_i | input | 1 | Slow-tracking one-shot end pulse |
| cnt1_en_o | output | 1 | First counter count enable |
| cnt2_en_o | output | 1 | Second counter count enable |
| capture_o | output | 1 | Third counter capture strobe |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
The properties assume the following about the inputs. `uflow_i`, `oneshot_end_i` and the tap inputs are single-cycle pulses synchronous to `clk_i`. A bus access is either a read or a write, never both in one cycle. The flag properties also rely on a flag leaving 1 only through the mode-register write path. The stimulus keeps to these assumptions: it pulses every event input for exactly one cycle, drives bus reads and bus writes in separate cycles, and holds each asynchronous pin for several cycles so that each change gives exactly one synchronized edge.

// File: rtl/tmr_mode_pkg.sv
package tmr_mode_pkg;
  localparam int DATA_W   = 8;
  localparam int TAP_N    = 6;
  localparam int EDGE_N   = 3;

  localparam bit REG_MODE = 1'b0;
  localparam bit REG_AUX  = 1'b1;

  // mode register field positions
  localparam int B_ISEL   = 4;
  localparam int B_CAPF   = 5;
  localparam int B_OSF    = 6;
  localparam int B_TRIG   = 7;

  // prescaler tap indices
  localparam int T_D4     = 0;
  localparam int T_D256   = 1;
  localparam int T_D512   = 2;
  localparam int T_D1024  = 3;
  localparam int T_D2048  = 4;
  localparam int T_D4096  = 5;

  // edge detector lanes
  localparam int E_EXT    = 0;
  localparam int E_DIV    = 1;
  localparam int E_PIN    = 2;

  typedef logic [1:0] src_sel_t;
endpackage

// File: rtl/tmr_edge_det.sv
module tmr_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  localparam int W = STAGES + 1;
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[W-2:0], pin_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tmr_src_mux.sv
module tmr_src_mux #(
  parameter int TAPS   = 6,
  parameter int IDX_01 = 0,
  parameter int IDX_10 = 1,
  parameter int IDX_11 = 2
) (
  input  tmr_mode_pkg::src_sel_t sel_i,
  input  logic [TAPS-1:0]        taps_i,
  input  logic                   edge_i,
  output logic                   en_o
);
  always_comb begin
    unique case (sel_i)
      2'b00:   en_o = edge_i;
      2'b01:   en_o = taps_i[IDX_01];
      2'b10:   en_o = taps_i[IDX_10];
      default: en_o = taps_i[IDX_11];
    endcase
  end
endmodule

// File: rtl/tmr_evt_flag.sv
module tmr_evt_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o,
  output logic rise_o
);
  logic flag_q, arm_q, clr;

  assign clr = wr_i & ~wbit_i & arm_q & flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (set_i)    flag_q <= 1'b1;   // set has priority over clear
      else if (clr) flag_q <= 1'b0;
      if (rd_i)     arm_q  <= flag_q;
      else if (wr_i) arm_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign rise_o = set_i & ~flag_q;
endmodule

// File: rtl/tmr_mode_ctl.sv
module tmr_mode_ctl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic       addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic [5:0] taps_i,
  input  logic       ext_cnt_i,
  input  logic       div_out_i,
  input  logic       irq_pin_i,
  input  logic       uflow_i,
  input  logic       oneshot_end_i,
  output logic       cnt1_en_o,
  output logic       cnt2_en_o,
  output logic       capture_o,
  output logic       irq_o
);
  import tmr_mode_pkg::*;

  logic     wr_mode, rd_mode, wr_aux;
  src_sel_t src1_q, src2_q;
  logic     isel_q, trig_q, pin_sel_q;
  logic     cap_flag, os_flag, cap_rise, os_rise, irq_q;
  logic [EDGE_N-1:0] pins, rises;

  assign wr_mode = sel_i & wr_i & (addr_i == REG_MODE);
  assign rd_mode = sel_i & rd_i & (addr_i == REG_MODE);
  assign wr_aux  = sel_i & wr_i & (addr_i == REG_AUX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src1_q    <= '0;
      src2_q    <= '0;
      isel_q    <= 1'b0;
      trig_q    <= 1'b0;
      pin_sel_q <= 1'b0;
    end else begin
      if (wr_mode) begin
        src1_q <= wdata_i[1:0];
        src2_q <= wdata_i[3:2];
        isel_q <= wdata_i[B_ISEL];
        trig_q <= wdata_i[B_TRIG];
      end
      if (wr_aux) pin_sel_q <= wdata_i[0];
    end
  end

  assign pins = {irq_pin_i, div_out_i, ext_cnt_i};

  for (genvar g = 0; g < EDGE_N; g++) begin : g_edge
    tmr_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pin_i (pins[g]),
      .rise_o(rises[g])
    );
  end

  tmr_src_mux #(.TAPS(TAP_N), .IDX_01(T_D4), .IDX_10(T_D256), .IDX_11(T_D512)) u_src1 (
    .sel_i (src1_q),
    .taps_i(taps_i),
    .edge_i(rises[E_EXT]),
    .en_o  (cnt1_en_o)
  );

  // non-monotonic ordering for the second counter
  tmr_src_mux #(.TAPS(TAP_N), .IDX_01(T_D4096), .IDX_10(T_D2048), .IDX_11(T_D1024)) u_src2 (
    .sel_i (src2_q),
    .taps_i(taps_i),
    .edge_i(rises[E_DIV]),
    .en_o  (cnt2_en_o)
  );

  assign capture_o = trig_q ? (pin_sel_q ? rises[E_PIN] : rises[E_EXT]) : uflow_i;

  tmr_evt_flag u_capf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (capture_o & ~isel_q),
    .rd_i  (rd_mode),
    .wr_i  (wr_mode),
    .wbit_i(wdata_i[B_CAPF]),
    .flag_o(cap_flag),
    .rise_o(cap_rise)
  );

  tmr_evt_flag u_osf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (oneshot_end_i & isel_q),
    .rd_i  (rd_mode),
    .wr_i  (wr_mode),
    .wbit_i(wdata_i[B_OSF]),
    .flag_o(os_flag),
    .rise_o(os_rise)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= cap_rise | os_rise;
  end
  assign irq_o = irq_q;

  always_comb begin
    rdata_o = '0;
    if (sel_i && rd_i) begin
      if (addr_i == REG_MODE) rdata_o = {trig_q, os_flag, cap_flag, isel_q, src2_q, src1_q};
      else                    rdata_o = {7'b0, pin_sel_q};
    end
  end
endmodule

// File: rtl/tmr_mode_ctl_chk.sv
module tmr_mode_ctl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sel_i,
  input logic       wr_i,
  input logic       addr_i,
  input logic [7:0] wdata_i,
  input logic       capture_o,
  input logic       oneshot_end_i,
  input logic       irq_o,
  input logic       isel_q,
  input logic       cap_flag,
  input logic       os_flag
);
  assert_capf_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_flag && isel_q) |=> !cap_flag);

  assert_osf_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!os_flag && !isel_q) |=> !os_flag);

  assert_capf_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_flag && !(sel_i && wr_i && !addr_i && !wdata_i[5])) |=> cap_flag);

  assert_osf_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (os_flag && !(sel_i && wr_i && !addr_i && !wdata_i[6])) |=> os_flag);

  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_o && !isel_q) |=> cap_flag);

  assert_set_wins_os_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oneshot_end_i && isel_q) |=> os_flag);

  assert_irq_on_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($rose(cap_flag) || $rose(os_flag)));

  assert_irq_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
endmodule

bind tmr_mode_ctl tmr_mode_ctl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sel_i        (sel_i),
  .wr_i         (wr_i),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .capture_o    (capture_o),
  .oneshot_end_i(oneshot_end_i),
  .irq_o        (irq_o),
  .isel_q       (isel_q),
  .cap_flag     (cap_flag),
  .os_flag      (os_flag)
);

// File: tb/tb_tmr_mode_ctl.sv
module tb_tmr_mode_ctl;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic sel_i = 0, wr_i = 0, rd_i = 0, addr_i = 0;
  logic [7:0] wdata_i = '0, rdata_o;
  logic [5:0] taps_i = '0;
  logic ext_cnt_i = 0, div_out_i = 0, irq_pin_i = 0, uflow_i = 0, oneshot_end_i = 0;
  logic cnt1_en_o, cnt2_en_o, capture_o, irq_o;

  int total = 0, bad = 0;
  bit done = 0;
  string exp_q[$];

  always #5 clk_i = ~clk_i;

  tmr_mode_ctl dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: every irq pulse must match a queued expectation
  always @(negedge clk_i) begin
    if (rst_ni && irq_o) begin
      if (exp_q.size() == 0) check(0, "R9 unexpected irq", 1, 0);
      else begin
        string r;
        r = exp_q.pop_front();
        check(1, r, 1, 1);
      end
    end
  end

  task automatic wr(input bit a, input logic [7:0] d);
    @(posedge clk_i); #1;
    sel_i = 1; wr_i = 1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    sel_i = 0; wr_i = 0; wdata_i = '0;
  endtask

  task automatic rd(input bit a, output logic [7:0] d);
    @(posedge clk_i); #1;
    sel_i = 1; rd_i = 1; addr_i = a;
    #4 d = rdata_o;
    @(posedge clk_i); #1;
    sel_i = 0; rd_i = 0;
  endtask

  task automatic rd_chk(input bit a, input logic [7:0] exp, input string req);
    logic [7:0] d;
    rd(a, d);
    check(d == exp, req, d, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk_i);
  endtask

  task automatic pulse_uflow(output bit cap);
    @(posedge clk_i); #1;
    uflow_i = 1;
    #4 cap = capture_o;
    @(posedge clk_i); #1;
    uflow_i = 0;
  endtask

  task automatic pulse_os();
    @(posedge clk_i); #1;
    oneshot_end_i = 1;
    @(posedge clk_i); #1;
    oneshot_end_i = 0;
  endtask

  task automatic tap_en(input int t, output bit e1, output bit e2);
    @(posedge clk_i); #1;
    taps_i = 6'(1 << t);
    #4 e1 = cnt1_en_o; e2 = cnt2_en_o;
    @(posedge clk_i); #1;
    taps_i = '0;
  endtask

  // raise one asynchronous pin, count enable/capture pulses
  task automatic pin_pulse(input int which, output int n1, output int n2, output int nc);
    n1 = 0; n2 = 0; nc = 0;
    @(posedge clk_i); #1;
    case (which)
      0: ext_cnt_i = 1;
      1: div_out_i = 1;
      default: irq_pin_i = 1;
    endcase
    for (int i = 0; i < 6; i++) begin
      @(posedge clk_i); #5;
      n1 += int'(cnt1_en_o); n2 += int'(cnt2_en_o); nc += int'(capture_o);
    end
    ext_cnt_i = 0; div_out_i = 0; irq_pin_i = 0;
    idle(4);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    bit b, e1, e2;
    int n1, n2, nc;
    int idx1[4] = '{-1, 0, 1, 2};
    int idx2[4] = '{-1, 5, 4, 3};

    idle(3);
    #1 check(irq_o == 0, "R1 irq after reset", irq_o, 0);
    rst_ni = 1;
    rd_chk(0, 8'h00, "R1 mode reset");
    rd_chk(1, 8'h00, "R1 aux reset");

    // R11 readback, flag bits not settable by write
    wr(0, 8'hFF);
    rd_chk(0, 8'h9F, "R11 mode readback");
    wr(1, 8'hFF);
    rd_chk(1, 8'h01, "R11 aux readback");
    wr(0, 8'h00);
    wr(1, 8'h00);

    // R2 / R3 tap selection
    for (int c = 1; c < 4; c++) begin
      wr(0, 8'((c << 2) | c));
      for (int t = 0; t < 6; t++) begin
        tap_en(t, e1, e2);
        check(e1 == (t == idx1[c]), "R2 cnt1 tap", e1, t == idx1[c]);
        check(e2 == (t == idx2[c]), "R3 cnt2 tap", e2, t == idx2[c]);
      end
    end
    wr(0, 8'h10);
    tap_en(0, e1, e2);
    check(e1 == 0 && e2 == 0, "R2 taps ignored in edge mode", {e1, e2}, 0);
    pin_pulse(0, n1, n2, nc);
    check(n1 == 1, "R2 ext edge counts once", n1, 1);
    check(n2 == 0, "R3 ext edge not on cnt2", n2, 0);
    pin_pulse(1, n1, n2, nc);
    check(n2 == 1, "R3 divider edge counts once", n2, 1);
    check(n1 == 0, "R2 divider edge not on cnt1", n1, 0);

    // R4 capture trigger (isel=1 keeps capture flag quiet)
    wr(1, 8'h01);
    pulse_uflow(b);
    check(b == 1, "R4 underflow capture, aux ignored", b, 1);
    pin_pulse(2, n1, n2, nc);
    check(nc == 0, "R4 pin ignored when latch bit 0", nc, 0);
    wr(0, 8'h90);
    pulse_uflow(b);
    check(b == 0, "R4 underflow ignored when latch bit 1", b, 0);
    pin_pulse(2, n1, n2, nc);
    check(nc == 1, "R4 irq pin capture", nc, 1);
    pin_pulse(0, n1, n2, nc);
    check(nc == 0, "R4 ext ignored with aux 1", nc, 0);
    wr(1, 8'h00);
    pin_pulse(0, n1, n2, nc);
    check(nc == 1, "R4 ext edge capture", nc, 1);
    pin_pulse(2, n1, n2, nc);
    check(nc == 0, "R4 pin ignored with aux 0", nc, 0);
    rd_chk(0, 8'h90, "R5 no capture flag while isel 1");

    // R5 / R9 capture flag and interrupt
    wr(0, 8'h00);
    exp_q.push_back("R9 capture irq");
    pulse_uflow(b);
    idle(2);
    rd_chk(0, 8'h20, "R5 capture flag set");
    pulse_uflow(b);
    idle(2);
    check(exp_q.size() == 0, "R9 capture irq seen", exp_q.size(), 0);
    // R10: non-clearing write drops the arm
    wr(0, 8'h20);
    wr(0, 8'h00);
    rd_chk(0, 8'h20, "R10 arm cancelled, flag kept");
    wr(0, 8'h00);
    rd_chk(0, 8'h00, "R7 read-then-write-0 clears");
    wr(0, 8'h00);
    rd_chk(0, 8'h00, "R7 stays clear");

    // R5 negative with isel=1
    wr(0, 8'h10);
    pulse_uflow(b);
    idle(2);
    rd_chk(0, 8'h10, "R5 capture ignored when isel 1");

    // R6 one-shot flag
    exp_q.push_back("R9 one-shot irq");
    pulse_os();
    idle(2);
    rd_chk(0, 8'h50, "R6 one-shot flag set");
    wr(0, 8'h50);
    rd_chk(0, 8'h50, "R7 writing 1 has no effect");
    wr(0, 8'h10);
    rd_chk(0, 8'h10, "R7 one-shot flag clears");
    wr(0, 8'h00);
    pulse_os();
    idle(2);
    rd_chk(0, 8'h00, "R6 one-shot ignored when isel 0");

    // R8 set wins over clear
    exp_q.push_back("R9 capture irq again");
    pulse_uflow(b);
    idle(2);
    rd_chk(0, 8'h20, "R8 flag set before race");
    @(posedge clk_i); #1;
    sel_i = 1; wr_i = 1; addr_i = 0; wdata_i = 8'h00; uflow_i = 1;
    @(posedge clk_i); #1;
    sel_i = 0; wr_i = 0; uflow_i = 0;
    rd_chk(0, 8'h20, "R8 set wins over clear");
    wr(0, 8'h00);
    rd_chk(0, 8'h00, "R8 later clear works");

    idle(4);
    check(exp_q.size() == 0, "R9 all irqs seen", exp_q.size(), 0);
    check(irq_o == 0, "R9 irq idle", irq_o, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule